// File: doc/BRIEF.md
# Variable-Length CAN Receive FIFO

This block holds received CAN frames in a 64-byte circular byte store. Each frame that arrives on the parallel frame input is packed into a record whose length depends on its format. A header byte comes first, then the identifier bytes, then the data bytes. The record is written one byte per clock. The host reads the oldest record through a small window. Window offset k returns the byte k places after the start pointer, with the address wrapping at the end of the store.

A release command frees the oldest record. The block works out that record's length again from the header byte held in the store, and moves the start pointer past it. A frame that would not fit in the free space is discarded whole and raises an overrun. While the controller is in reset mode the block takes no frames. When it leaves reset mode the message count and the byte count are cleared.

Top module: `can_rxq`

## Requirements
- R1: The byte at window offset 0 of a record is the header: bit 7 is the extended-format flag, bit 6 is the remote-request flag, bits 5:4 are 0 and bits 3:0 are the DLC exactly as received.
- R2: In an extended record, offsets 1 to 4 hold identifier bits 28:21, then 20:13, then 12:5, then bits 4:0 placed in bits 7:3 with bits 2:0 zero. Data byte i sits at offset 5+i, and data byte 0 is `frm_data[7:0]`.
- R3: In a standard record, offset 1 holds identifier bits 10:3, and offset 2 holds identifier bits 2:0 in bits 7:5 with bits 4:0 zero. Data byte i sits at offset 3+i.
- R4: The record length is 3, plus 2 for an extended frame, plus the data count. A frame is stored when the stored byte count plus its length is at most 64, so the store can become exactly full.
- R5: A frame that would push the byte count over 64 is discarded entirely. It writes no byte, `overrun` sets and stays set until `clr_ovr`, and `irq_ovr` pulses for one cycle.
- R6: `rel_cmd` advances the start pointer by the length recomputed from the oldest header, modulo 64. When no record is held, `rel_cmd` changes nothing.
- R7: `irq_rx` pulses for one cycle, in the cycle after the last byte of a record is written. `rx_full` is high while at least one record is held and drops when the last record is released.
- R8: A remote frame stores no data bytes whatever its DLC. A data frame with DLC above 8 stores 8 data bytes.
- R9: While `reset_mode` is high, offered frames are ignored. When `reset_mode` falls, both counts clear and `rx_full` drops. The next record then appears at window offset 0.
- R10: Records and window reads wrap correctly across the end of the 64-byte store.
- R11: When a record's last byte is written in the same cycle as `rel_cmd`, the write is counted first and that record is then released.
- R12: A record of length L keeps `wr_busy` high for exactly L cycles. Frames offered while `wr_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_mode | input | 1 | Controller is in reset mode |
| frm_valid | input | 1 | A parsed frame is offered this cycle |
| frm_ext | input | 1 | Extended-format identifier |
| frm_rtr | input | 1 | Remote-request frame |
| frm_dlc | input | 4 | Data length code |
| frm_id | input | 29 | Identifier (standard uses bits 10:0) |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| rel_cmd | input | 1 | Release the oldest record |
| clr_ovr | input | 1 | Clear the overrun status |
| win_off | input | 4 | Read window offset from the start pointer |
| win_data | output | 8 | Byte at start + offset |
| wr_busy | output | 1 | A record is being written |
| rx_full | output | 1 | At least one record is held |
| overrun | output | 1 | A frame was discarded for lack of room |
| irq_rx | output | 1 | Record-complete pulse |
| irq_ovr | output | 1 | Overrun pulse |

## Verification
A release can land in the same cycle as the final byte write of an incoming record. This is the case where the counts move in opposite directions at once. The bench provokes it by sending a frame into an empty store and raising `rel_cmd` exactly in the cycle the last byte is written. The result is judged at the ports. `rx_full` must end low while `irq_rx` still pulses, and the next frame sent must appear at window offset 0, which shows that the start pointer moved past the full recomputed length.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;

    localparam int unsigned ID_W     = 29;
    localparam int unsigned MAX_DATA = 8;
    localparam int unsigned LEN_W    = 4;

    typedef struct packed {
        logic                   ext;
        logic                   rtr;
        logic [3:0]             dlc;
        logic [ID_W-1:0]        id;
        logic [8*MAX_DATA-1:0]  data;
    } can_frame_t;

    // number of data bytes a frame stores
    function automatic logic [LEN_W-1:0] data_cnt(logic rtr, logic [3:0] dlc);
        if (rtr)
            return '0;
        return (dlc > 4'd8) ? 4'd8 : dlc;
    endfunction

    function automatic logic [LEN_W-1:0] rec_len(logic ext, logic rtr, logic [3:0] dlc);
        return 4'd3 + (ext ? 4'd2 : 4'd0) + data_cnt(rtr, dlc);
    endfunction

    function automatic logic [7:0] hdr_of(can_frame_t f);
        return {f.ext, f.rtr, 2'b00, f.dlc};
    endfunction

    // length recomputed from a stored header byte
    function automatic logic [LEN_W-1:0] hdr_len(logic [7:0] h);
        return rec_len(h[7], h[6], h[3:0]);
    endfunction

    // byte idx of the packed record for frame f
    function automatic logic [7:0] rec_byte(can_frame_t f, logic [LEN_W-1:0] idx);
        logic [LEN_W-1:0] dofs;
        logic [LEN_W-1:0] di;
        logic [7:0]       b;
        dofs = f.ext ? 4'd5 : 4'd3;
        di   = idx - dofs;
        b    = f.data[{di[2:0], 3'b000} +: 8];
        if (idx == '0) begin
            b = hdr_of(f);
        end else if (f.ext) begin
            case (idx)
                4'd1: b = f.id[28:21];
                4'd2: b = f.id[20:13];
                4'd3: b = f.id[12:5];
                4'd4: b = {f.id[4:0], 3'b000};
                default: ;
            endcase
        end else begin
            case (idx)
                4'd1: b = f.id[10:3];
                4'd2: b = {f.id[2:0], 5'b00000};
                default: ;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/can_rxq_mem.sv
module can_rxq_mem #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    input  logic [AW-1:0] haddr,
    output logic [7:0]    hdata
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
    assign hdata = store[haddr];

endmodule

// File: rtl/can_rxq_pack.sv
module can_rxq_pack
    import can_rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reset_mode,
    input  logic             rx_enable,
    input  logic             frm_valid,
    input  can_frame_t       frame,
    input  logic             fits,
    output logic [LEN_W-1:0] offer_len,
    output logic             accept,
    output logic             drop,
    output logic             busy,
    output logic             wr_en,
    output logic [7:0]       wr_byte,
    output logic             done
);

    can_frame_t       cur;
    logic [LEN_W-1:0] cur_len;
    logic [LEN_W-1:0] idx;
    logic             attempt;
    logic             last;

    assign offer_len = rec_len(frame.ext, frame.rtr, frame.dlc);
    assign attempt   = frm_valid && !busy && rx_enable;
    assign accept    = attempt && fits;
    assign drop      = attempt && !fits;
    assign last      = (idx == cur_len - 4'd1);

    assign wr_en   = busy && !reset_mode;
    assign wr_byte = rec_byte(cur, idx);
    assign done    = wr_en && last;

    always_ff @(posedge clk) begin
        if (rst || reset_mode) begin
            busy    <= 1'b0;
            idx     <= '0;
            cur_len <= 4'd3;
            cur     <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            idx     <= '0;
            cur_len <= offer_len;
            cur     <= frame;
        end else if (busy) begin
            idx <= idx + 4'd1;
            if (last)
                busy <= 1'b0;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        reset_mode |=> !busy); // R9

    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        drop |=> !busy); // R5

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx < cur_len)); // R12

endmodule

// File: rtl/can_rxq_ctrl.sv
module can_rxq_ctrl
    import can_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reset_mode,
    input  logic [LEN_W-1:0] offer_len,
    input  logic             accept,
    input  logic             drop,
    input  logic             wr_en,
    input  logic             done,
    input  logic             rel_cmd,
    input  logic             clr_ovr,
    input  logic [7:0]       head_hdr,
    output logic             rx_enable,
    output logic             fits,
    output logic [AW-1:0]    wptr,
    output logic [AW-1:0]    start,
    output logic             rx_full,
    output logic             overrun,
    output logic             irq_rx,
    output logic             irq_ovr
);

    logic [CW-1:0]    msg_cnt;
    logic [CW-1:0]    byte_cnt;
    logic             rm_q;
    logic             leave;
    logic             rel_ok;
    logic [LEN_W-1:0] rel_len;
    logic [CW:0]      need;

    assign leave     = rm_q && !reset_mode;
    assign rx_enable = !reset_mode && !rm_q;
    assign need      = {1'b0, byte_cnt} + (CW+1)'(offer_len);
    assign fits      = need <= (CW+1)'(DEPTH);
    assign rel_len   = hdr_len(head_hdr);
    // a record finishing this cycle counts before the release
    assign rel_ok    = rel_cmd && !reset_mode && !leave && ((msg_cnt != '0) || done);
    assign rx_full   = (msg_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rm_q     <= 1'b0;
            msg_cnt  <= '0;
            byte_cnt <= '0;
            wptr     <= '0;
            start    <= '0;
            overrun  <= 1'b0;
            irq_rx   <= 1'b0;
            irq_ovr  <= 1'b0;
        end else begin
            rm_q    <= reset_mode;
            irq_rx  <= done;
            irq_ovr <= drop;
            if (wr_en)
                wptr <= wptr + AW'(1);
            if (leave) begin
                msg_cnt  <= '0;
                byte_cnt <= '0;
                start    <= wptr;
            end else begin
                msg_cnt  <= msg_cnt + CW'(done) - CW'(rel_ok);
                byte_cnt <= byte_cnt
                          + (accept ? CW'(offer_len) : CW'(0))
                          - (rel_ok ? CW'(rel_len) : CW'(0));
                if (rel_ok)
                    start <= start + AW'(rel_len);
            end
            if (drop)
                overrun <= 1'b1;
            else if (clr_ovr)
                overrun <= 1'b0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        byte_cnt <= CW'(DEPTH)); // R4

    AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rel_cmd && (msg_cnt == '0) && !done && !leave) |=> $stable(start)); // R6

    AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_rx |=> !irq_rx); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_ovr) |=> overrun); // R5

    AST_LEAVE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        leave |=> !rx_full); // R9

endmodule

// File: rtl/can_rxq.sv
module can_rxq
    import can_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIN_W = 4,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reset_mode,
    input  logic             frm_valid,
    input  logic             frm_ext,
    input  logic             frm_rtr,
    input  logic [3:0]       frm_dlc,
    input  logic [ID_W-1:0]  frm_id,
    input  logic [63:0]      frm_data,
    input  logic             rel_cmd,
    input  logic             clr_ovr,
    input  logic [WIN_W-1:0] win_off,
    output logic [7:0]       win_data,
    output logic             wr_busy,
    output logic             rx_full,
    output logic             overrun,
    output logic             irq_rx,
    output logic             irq_ovr
);

    can_frame_t       frame;
    logic [LEN_W-1:0] offer_len;
    logic             accept, drop, busy, wr_en, done;
    logic [7:0]       wr_byte;
    logic             rx_enable, fits;
    logic [AW-1:0]    wptr, start, raddr;
    logic [7:0]       head_hdr;

    assign frame   = '{ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc, id: frm_id, data: frm_data};
    assign raddr   = start + AW'(win_off);
    assign wr_busy = busy;

    can_rxq_pack u_pack (
        .clk        (clk),
        .rst        (rst),
        .reset_mode (reset_mode),
        .rx_enable  (rx_enable),
        .frm_valid  (frm_valid),
        .frame      (frame),
        .fits       (fits),
        .offer_len  (offer_len),
        .accept     (accept),
        .drop       (drop),
        .busy       (busy),
        .wr_en      (wr_en),
        .wr_byte    (wr_byte),
        .done       (done)
    );

    can_rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .reset_mode (reset_mode),
        .offer_len  (offer_len),
        .accept     (accept),
        .drop       (drop),
        .wr_en      (wr_en),
        .done       (done),
        .rel_cmd    (rel_cmd),
        .clr_ovr    (clr_ovr),
        .head_hdr   (head_hdr),
        .rx_enable  (rx_enable),
        .fits       (fits),
        .wptr       (wptr),
        .start      (start),
        .rx_full    (rx_full),
        .overrun    (overrun),
        .irq_rx     (irq_rx),
        .irq_ovr    (irq_ovr)
    );

    can_rxq_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wptr),
        .wdata (wr_byte),
        .raddr (raddr),
        .rdata (win_data),
        .haddr (start),
        .hdata (head_hdr)
    );

endmodule

// File: tb/can_rxq_test.sv
`timescale 1ns/1ps
module can_rxq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reset_mode = 1'b0;
    logic        frm_valid = 1'b0;
    logic        frm_ext = 1'b0;
    logic        frm_rtr = 1'b0;
    logic [3:0]  frm_dlc = '0;
    logic [28:0] frm_id = '0;
    logic [63:0] frm_data = '0;
    logic        rel_cmd = 1'b0;
    logic        clr_ovr = 1'b0;
    logic [3:0]  win_off = '0;
    logic [7:0]  win_data;
    logic        wr_busy, rx_full, overrun, irq_rx, irq_ovr;

    int nchk = 0;
    int nerr = 0;
    int used = 0;
    bit done_flag = 0;
    logic [7:0] exp_bytes[$];
    int         exp_len[$];

    always #5 clk = ~clk;

    can_rxq uut (
        .clk(clk), .rst(rst), .reset_mode(reset_mode), .frm_valid(frm_valid),
        .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_id(frm_id),
        .frm_data(frm_data), .rel_cmd(rel_cmd), .clr_ovr(clr_ovr), .win_off(win_off),
        .win_data(win_data), .wr_busy(wr_busy), .rx_full(rx_full), .overrun(overrun),
        .irq_rx(irq_rx), .irq_ovr(irq_ovr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int len_of(input logic e, input logic r, input logic [3:0] d);
        int nd;
        nd = r ? 0 : ((d > 4'd8) ? 8 : int'(d));
        return 3 + (e ? 2 : 0) + nd;
    endfunction

    // scoreboard driver side: expected record bytes
    task automatic expect_push(input logic e, input logic r, input logic [3:0] d,
                               input logic [28:0] id, input logic [63:0] dat);
        int nd;
        nd = len_of(e, r, d) - 3 - (e ? 2 : 0);
        exp_bytes.push_back({e, r, 2'b00, d});
        if (e) begin
            exp_bytes.push_back(8'((id >> 21) & 29'hff));
            exp_bytes.push_back(8'((id >> 13) & 29'hff));
            exp_bytes.push_back(8'((id >> 5) & 29'hff));
            exp_bytes.push_back(8'((id & 29'h1f) << 3));
        end else begin
            exp_bytes.push_back(8'((id >> 3) & 29'hff));
            exp_bytes.push_back(8'((id & 29'h7) << 5));
        end
        for (int i = 0; i < nd; i++)
            exp_bytes.push_back(dat[8*i +: 8]);
        exp_len.push_back(len_of(e, r, d));
    endtask

    task automatic put_inputs(input logic e, input logic r, input logic [3:0] d,
                              input logic [28:0] id, input logic [63:0] dat);
        frm_ext = e; frm_rtr = r; frm_dlc = d; frm_id = id; frm_data = dat;
    endtask

    task automatic drive(input logic e, input logic r, input logic [3:0] d,
                         input logic [28:0] id, input logic [63:0] dat);
        @(negedge clk);
        put_inputs(e, r, d, id, dat);
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic send(input logic e, input logic r, input logic [3:0] d,
                        input logic [28:0] id, input logic [63:0] dat);
        int L;
        int n;
        L = len_of(e, r, d);
        if (used + L <= 64) begin
            expect_push(e, r, d, id, dat);
            used += L;
            drive(e, r, d, id, dat);
            n = 0;
            while (wr_busy && n < 40) begin
                n++;
                @(negedge clk);
            end
            check(n == L, "R12 busy cycles equal record length", n, L);
            check(irq_rx == 1'b1, "R7 irq_rx after last byte", irq_rx, 1);
            check(rx_full == 1'b1, "R7 rx_full with record held", rx_full, 1);
        end else begin
            drive(e, r, d, id, dat);
            check(wr_busy == 1'b0, "R5 dropped frame writes nothing", wr_busy, 0);
            check(irq_ovr == 1'b1, "R5 irq_ovr pulse", irq_ovr, 1);
            check(overrun == 1'b1, "R5 overrun status", overrun, 1);
        end
    endtask

    // scoreboard monitor side: compare the head record through the window
    task automatic check_head(input string tag);
        int L;
        L = exp_len[0];
        for (int k = 0; k < L; k++) begin
            win_off = 4'(k);
            #0.1;
            check(win_data == exp_bytes[k], tag, win_data, exp_bytes[k]);
        end
    endtask

    task automatic rel_pulse();
        @(negedge clk);
        rel_cmd = 1'b1;
        @(negedge clk);
        rel_cmd = 1'b0;
    endtask

    task automatic release_head();
        int L;
        L = exp_len.pop_front();
        for (int k = 0; k < L; k++)
            void'(exp_bytes.pop_front());
        used -= L;
        rel_pulse();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int L;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rx_full == 1'b0, "R7 reset rx_full", rx_full, 0);
        check(overrun == 1'b0, "R5 reset overrun", overrun, 0);
        check(wr_busy == 1'b0, "R12 reset busy", wr_busy, 0);
        check(irq_rx == 1'b0 && irq_ovr == 1'b0, "R7 reset irqs", {irq_rx, irq_ovr}, 0);

        // standard and extended data frames
        send(1'b0, 1'b0, 4'd3, 29'h5A3, 64'h0000_0000_00C3_B2A1);
        check_head("R3 standard record");
        check_head("R1 header byte");
        release_head();
        check(rx_full == 1'b0, "R7 rx_full after last release", rx_full, 1'b0);
        send(1'b1, 1'b0, 4'd2, 29'h1ABCDE12, 64'h0000_0000_0000_9F8E);
        check_head("R2 extended record");
        release_head();

        // several queued records, remote and oversize DLC
        send(1'b0, 1'b1, 4'd5, 29'h07F, 64'hFFFF_FFFF_FFFF_FFFF);
        send(1'b1, 1'b1, 4'd8, 29'h00012345, 64'h1111_1111_1111_1111);
        send(1'b0, 1'b0, 4'd12, 29'h123, 64'h8877_6655_4433_2211);
        check_head("R8 remote standard stores no data");
        release_head();
        check_head("R8 remote extended stores no data");
        release_head();
        check_head("R8 DLC above 8 stores 8 bytes");
        release_head();
        check(rx_full == 1'b0, "R7 rx_full after draining", rx_full, 0);

        // release with nothing held
        rel_pulse();
        check(rx_full == 1'b0, "R6 empty release keeps empty", rx_full, 0);
        send(1'b0, 1'b0, 4'd1, 29'h2AA, 64'h5C);
        check_head("R6 start unchanged by empty release");
        release_head();

        // fill exactly, then overflow
        for (int i = 0; i < 4; i++)
            send(1'b1, 1'b0, 4'd8, 29'h1000_0000 + 29'(i), 64'h0102_0304_0506_0708 + 64'(i));
        send(1'b1, 1'b0, 4'd7, 29'h0ABCDEF, 64'h00AA_BBCC_DDEE_FF01);
        check(used == 64, "R4 store exactly full", used, 64);
        send(1'b0, 1'b0, 4'd0, 29'h001, 64'h0);
        @(negedge clk);
        check(irq_ovr == 1'b0, "R5 irq_ovr single cycle", irq_ovr, 0);
        check(overrun == 1'b1, "R5 overrun sticky", overrun, 1);
        @(negedge clk);
        clr_ovr = 1'b1;
        @(negedge clk);
        clr_ovr = 1'b0;
        check(overrun == 1'b0, "R5 clr_ovr clears", overrun, 0);
        while (exp_len.size() > 0) begin
            check_head("R4 records intact after drop");
            release_head();
        end
        check(rx_full == 1'b0, "R5 dropped frame left no record", rx_full, 0);

        // wrap across the end of the store
        for (int i = 0; i < 12; i++) begin
            send(1'b0, 1'b0, 4'd8, 29'(i * 37), {8{8'(i * 13 + 1)}} ^ 64'h0123_4567_89AB_CDEF);
            check_head("R10 window wraps");
            release_head();
        end

        // frame offered while busy is ignored
        expect_push(1'b0, 1'b0, 4'd4, 29'h3C5, 64'h4433_2211);
        used += 7;
        drive(1'b0, 1'b0, 4'd4, 29'h3C5, 64'h4433_2211);
        put_inputs(1'b1, 1'b0, 4'd8, 29'h1FFFFFFF, 64'hDEAD);
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        while (wr_busy) @(negedge clk);
        check_head("R12 first frame stored");
        release_head();
        repeat (2) @(negedge clk);
        check(rx_full == 1'b0, "R12 busy-time frame ignored", rx_full, 0);

        // reset mode behaviour
        send(1'b0, 1'b0, 4'd2, 29'h111, 64'h7766);
        @(negedge clk);
        reset_mode = 1'b1;
        drive(1'b0, 1'b0, 4'd1, 29'h222, 64'h55);
        check(wr_busy == 1'b0 && irq_ovr == 1'b0, "R9 frame ignored in reset mode", {wr_busy, irq_ovr}, 0);
        reset_mode = 1'b0;
        repeat (2) @(negedge clk);
        check(rx_full == 1'b0, "R9 leaving reset clears counts", rx_full, 0);
        exp_bytes.delete();
        exp_len.delete();
        used = 0;
        send(1'b1, 1'b0, 4'd3, 29'h0765_4321, 64'h00EE_DDCC);
        check_head("R9 new record at offset 0");
        release_head();

        // completion and release in the same cycle
        L = len_of(1'b0, 1'b0, 4'd1);
        drive(1'b0, 1'b0, 4'd1, 29'h6B1, 64'h3D);
        repeat (L - 1) @(negedge clk);
        rel_cmd = 1'b1;
        @(negedge clk);
        rel_cmd = 1'b0;
        check(irq_rx == 1'b1, "R11 record still completes", irq_rx, 1);
        check(rx_full == 1'b0, "R11 write counted then released", rx_full, 0);
        send(1'b0, 1'b0, 4'd2, 29'h4D2, 64'hA5A5);
        check_head("R11 start advanced by full length");
        release_head();

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule